// File: doc/BRIEF.md
# Dual Stack Pointer and Interrupt Entry Sequencer

This block keeps the two stack pointers of a processor core whose data memory is four bits wide. It also runs the memory sequences for calls, returns and interrupt entry. The address stack holds 16-bit program addresses and return values. Each entry takes four consecutive nibble words, and the entry is indexed by an 8-bit pointer counted in units of four words. The data stack holds single nibbles, such as saved registers or the flag register, and its 8-bit pointer addresses one word per step. Both pointers wrap modulo 256.

The surrounding core issues one command at a time on a 4-bit command code. The block performs one memory access per cycle and reports `busy_o` while a sequence is running. At the end of a sequence it may pulse `pc_load_o` with a new program counter. An interrupt gate output tells the interrupt controller whether hardware interrupts may be taken. The gate stays closed from reset until software has loaded both pointers. It also closes between the first and the second load of a pointer pair. Software interrupts ignore the gate. The memory read path is combinational: `mem_rdata_i` must reflect `mem_addr_o` in the same cycle.

Top module: `dstack_entry`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers become 00H, `busy_o`, `irq_gate_o`, `mem_we_o`, `mem_re_o` and `pc_load_o` become 0.
- R2: Command codes are 0 none, 1 nibble push, 2 nibble pop, 3 word push, 4 word pop, 5 call, 6 return, 7 software interrupt, 8 hardware interrupt, 9 load address-stack pointer, 10 load data-stack pointer. A command is taken only in a cycle where `busy_o` is 0. Codes 11 to 15, and any code presented while busy, change neither pointer nor any output.
- R3: A nibble push decrements the data-stack pointer at the accepting edge. In the next cycle it writes `nib_i` at address equal to the new pointer value. A nibble pop reads at the current pointer in the cycle after acceptance, then presents the nibble on `nib_o` with a one-cycle `nib_vld_o` and increments the pointer.
- R4: A word push decrements the address-stack pointer P at the accepting edge. In the four following cycles it writes address P*4+k for k = 0,1,2,3, carrying value bits 4k+3..4k, so the least significant nibble sits at the lowest address.
- R5: A word pop or a return reads addresses P*4+0..P*4+3 in four cycles and assembles them in the R4 order. After the last read the pointer increments. A pop then gives the value on `word_o` with a one-cycle `word_vld_o`. A return gives it on `pc_o` with a one-cycle `pc_load_o`.
- R6: Both pointers wrap cyclically within 8 bits: decrementing 00H gives FFH and incrementing FFH gives 00H.
- R7: A call pushes `pc_i`+1 as in R4 and then pulses `pc_load_o` with `pc_o` = `word_i` as captured at acceptance.
- R8: A software interrupt writes `flags_i` to the data stack as in R3 in the first cycle. It then decrements the address-stack pointer and pushes `pc_i`+1 as in R4. Finally it pulses `pc_load_o` with `pc_o` = 0100H + `vec_i` (0100H..013FH) and `ie_clr_o` = 0. It is taken whatever the gate state.
- R9: A hardware interrupt follows the R8 sequence and additionally pulses `ie_clr_o` together with `pc_load_o`. While `irq_gate_o` is 0, it is ignored completely.
- R10: `irq_gate_o` is 0 after reset. It becomes 1 only once both pointers have been loaded. Loading one pointer while the gate is open closes it until the other pointer is loaded.
- R11: A pointer load takes `sp_val_i` at the accepting edge, is visible on `sp1_o`/`sp2_o` in the next cycle, and never raises `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 4 | Command code (see R2) |
| word_i | input | 16 | Value for word push; call target |
| nib_i | input | 4 | Value for nibble push |
| flags_i | input | 4 | Flag register, saved on interrupt entry |
| pc_i | input | 16 | Address of the current instruction |
| sp_val_i | input | 8 | Value for pointer loads |
| vec_i | input | 6 | Interrupt vector number |
| mem_rdata_i | input | 4 | Read data for `mem_addr_o`, same cycle |
| busy_o | output | 1 | Sequence in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 4 | Memory write data |
| pc_load_o | output | 1 | Load `pc_o` into the program counter |
| pc_o | output | 16 | New program counter |
| ie_clr_o | output | 1 | Clear the interrupt enable flag |
| word_vld_o | output | 1 | `word_o` holds a popped word |
| word_o | output | 16 | Popped word |
| nib_vld_o | output | 1 | `nib_o` holds a popped nibble |
| nib_o | output | 4 | Popped nibble |
| irq_gate_o | output | 1 | Hardware interrupts allowed |
| sp1_o | output | 8 | Address-stack pointer |
| sp2_o | output | 8 | Data-stack pointer |

## Verification
The sequences are first tried with both pointers at 00H. This shows whether the decrement wraps to FFH and lands on words 3FCH..3FFH, and whether a return brings the pointer back to 00H. Pushes of two distinct words followed by two pops tell LIFO order apart from FIFO order. Asymmetric values such as BEEFH and 1357H separate the correct nibble order from a reversed one. Calls, software interrupts and hardware interrupts are compared against each other on the target PC, the flag write ahead of the address push, and the enable-clear pulse. Load sequences in the orders SP1-SP2, SP2-SP2 and SP2-SP1 separate a correct pairing gate from a sticky "both seen" flag.

// File: rtl/dse_pkg.sv
// Shared types for the dual stack sequencer: command codes, sequencer
// states and the action taken when a sequence completes.
package dse_pkg;

    typedef enum logic [3:0] {
        C_NOP   = 4'd0,
        C_PUSHN = 4'd1,
        C_POPN  = 4'd2,
        C_PUSHW = 4'd3,
        C_POPW  = 4'd4,
        C_CALL  = 4'd5,
        C_RET   = 4'd6,
        C_SWI   = 4'd7,
        C_HWI   = 4'd8,
        C_LDSP1 = 4'd9,
        C_LDSP2 = 4'd10
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NWR,
        S_NRD,
        S_FWR,
        S_WWR,
        S_WRD
    } state_e;

    typedef enum logic [1:0] {
        F_NONE,
        F_PC,
        F_WORD
    } fin_e;

endpackage

// File: rtl/dse_ptr.sv
// Cyclic stack pointer register.
// Load has priority over decrement, and decrement over increment.
// Arithmetic wraps within W bits.
// Assumes at most one of inc/dec is requested per cycle.
module dse_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         dec_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] q_o
);

    // Pointer update: reset to zero, then load / decrement / increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (ld_i) begin
            q_o <= ld_val_i;
        end else if (dec_i) begin
            q_o <= q_o - W'(1);
        end else if (inc_i) begin
            q_o <= q_o + W'(1);
        end
    end

endmodule

// File: rtl/dse_gate.sv
// Interrupt gate tracking the pointer-load pair.
// The gate opens once both pointers have been written since reset.
// It stays closed while a pair is half done.
// Assumes ld1_i and ld2_i are never high together.
module dse_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ld1_i,
    input  logic ld2_i,
    output logic open_o
);

    typedef enum logic [1:0] {P_NONE, P_WANT1, P_WANT2} pend_e;

    logic  seen1, seen2;
    pend_e pend;

    // Remember which pointers were ever loaded and which half of a pair is missing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
            pend  <= P_NONE;
        end else if (ld1_i) begin
            seen1 <= 1'b1;
            pend  <= (pend == P_WANT1) ? P_NONE : P_WANT2;
        end else if (ld2_i) begin
            seen2 <= 1'b1;
            pend  <= (pend == P_WANT2) ? P_NONE : P_WANT1;
        end
    end

    // Gate is open only with both seen and no pair pending.
    always_comb open_o = seen1 && seen2 && (pend == P_NONE);

    p_gate_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(ld1_i || ld2_i));

endmodule

// File: rtl/dse_seq.sv
// Stack access sequencer. It accepts one command when idle and then runs
// one nibble memory access per cycle.
// - Nibble stack: one access.
// - Word stack: four accesses, least significant nibble at the lowest address.
// - Interrupt entry: a flag write first, then the return address.
// The pointer registers live outside and are driven through inc/dec/ld strobes.
// Assumes memory read data is valid in the same cycle as the address.
module dse_seq
    import dse_pkg::*;
#(
    parameter int                 PC_W     = 16,
    parameter int                 NIB_W    = 4,
    parameter int                 SP_W     = 8,
    parameter int                 ADDR_W   = 16,
    parameter int                 VEC_W    = 6,
    parameter logic [PC_W-1:0]    VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [PC_W-1:0]   word_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic [NIB_W-1:0]  flags_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [NIB_W-1:0]  mem_rdata_i,
    input  logic [SP_W-1:0]   sp1_i,
    input  logic [SP_W-1:0]   sp2_i,
    input  logic              gate_i,
    output logic              sp1_inc_o,
    output logic              sp1_dec_o,
    output logic              sp2_inc_o,
    output logic              sp2_dec_o,
    output logic              ld1_o,
    output logic              ld2_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [NIB_W-1:0]  mem_wdata_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_o,
    output logic              ie_clr_o,
    output logic              word_vld_o,
    output logic [PC_W-1:0]   word_o,
    output logic              nib_vld_o,
    output logic [NIB_W-1:0]  nib_o
);

    localparam int WORDS = PC_W / NIB_W;
    localparam int CNT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    state_e           st;
    fin_e             fin;
    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0]  wbuf, tgt, asm_w;
    logic [NIB_W-1:0] nbuf;
    logic             hw;
    logic             acc, known;

    // Command acceptance: idle, a defined code, and a masked hardware interrupt refused.
    always_comb begin
        known  = (cmd_i >= C_PUSHN) && (cmd_i <= C_LDSP2);
        busy_o = (st != S_IDLE);
        acc    = !busy_o && known && !((cmd_i == C_HWI) && !gate_i);
    end

    // Pointer strobes for each command and sequence step.
    always_comb begin
        ld1_o     = acc && (cmd_i == C_LDSP1);
        ld2_o     = acc && (cmd_i == C_LDSP2);
        sp2_dec_o = acc && ((cmd_i == C_PUSHN) || (cmd_i == C_SWI) || (cmd_i == C_HWI));
        sp1_dec_o = (acc && ((cmd_i == C_PUSHW) || (cmd_i == C_CALL))) || (st == S_FWR);
        sp2_inc_o = (st == S_NRD);
        sp1_inc_o = (st == S_WRD) && (cnt == LAST);
    end

    // Merge the current read nibble into the word being popped.
    always_comb begin
        asm_w = wbuf;
        asm_w[cnt*NIB_W +: NIB_W] = mem_rdata_i;
    end

    // Memory strobes, address and write data for the current step.
    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = ADDR_W'(sp2_i);
        mem_wdata_o = nbuf;
        unique case (st)
            S_NWR, S_FWR: mem_we_o = 1'b1;
            S_NRD:        mem_re_o = 1'b1;
            S_WWR: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ADDR_W'({sp1_i, cnt});
                mem_wdata_o = wbuf[cnt*NIB_W +: NIB_W];
            end
            S_WRD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = ADDR_W'({sp1_i, cnt});
            end
            default: ;
        endcase
    end

    // Sequencer state, operand capture and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            fin        <= F_NONE;
            cnt        <= '0;
            wbuf       <= '0;
            tgt        <= '0;
            nbuf       <= '0;
            hw         <= 1'b0;
            pc_load_o  <= 1'b0;
            pc_o       <= '0;
            ie_clr_o   <= 1'b0;
            word_vld_o <= 1'b0;
            word_o     <= '0;
            nib_vld_o  <= 1'b0;
            nib_o      <= '0;
        end else begin
            pc_load_o  <= 1'b0;
            ie_clr_o   <= 1'b0;
            word_vld_o <= 1'b0;
            nib_vld_o  <= 1'b0;
            unique case (st)
                S_IDLE: if (acc) begin
                    cnt <= '0;
                    hw  <= (cmd_i == C_HWI);
                    unique case (cmd_i)
                        C_PUSHN: begin
                            nbuf <= nib_i;
                            st   <= S_NWR;
                        end
                        C_POPN: st <= S_NRD;
                        C_PUSHW: begin
                            wbuf <= word_i;
                            fin  <= F_NONE;
                            st   <= S_WWR;
                        end
                        C_POPW: begin
                            fin <= F_WORD;
                            st  <= S_WRD;
                        end
                        C_CALL: begin
                            wbuf <= pc_i + PC_W'(1);
                            tgt  <= word_i;
                            fin  <= F_PC;
                            st   <= S_WWR;
                        end
                        C_RET: begin
                            fin <= F_PC;
                            st  <= S_WRD;
                        end
                        C_SWI, C_HWI: begin
                            nbuf <= flags_i;
                            wbuf <= pc_i + PC_W'(1);
                            tgt  <= VEC_BASE + PC_W'(vec_i);
                            fin  <= F_PC;
                            st   <= S_FWR;
                        end
                        default: ;
                    endcase
                end
                S_NWR: st <= S_IDLE;
                S_NRD: begin
                    nib_o     <= mem_rdata_i;
                    nib_vld_o <= 1'b1;
                    st        <= S_IDLE;
                end
                S_FWR: begin
                    cnt <= '0;
                    st  <= S_WWR;
                end
                S_WWR: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == LAST) begin
                        st <= S_IDLE;
                        if (fin == F_PC) begin
                            pc_load_o <= 1'b1;
                            pc_o      <= tgt;
                            ie_clr_o  <= hw;
                        end
                    end
                end
                S_WRD: begin
                    wbuf <= asm_w;
                    cnt  <= cnt + CNT_W'(1);
                    if (cnt == LAST) begin
                        st <= S_IDLE;
                        if (fin == F_PC) begin
                            pc_load_o <= 1'b1;
                            pc_o      <= asm_w;
                        end else begin
                            word_vld_o <= 1'b1;
                            word_o     <= asm_w;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_pc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    p_ieclr_with_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_o |-> pc_load_o);

endmodule

// File: rtl/dstack_entry.sv
// Top of the dual stack pointer and interrupt entry block.
// It connects the two cyclic pointers, the interrupt gate and the access sequencer.
// Memory is external; its read path is assumed combinational.
module dstack_entry
    import dse_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              NIB_W    = 4,
    parameter int              SP_W     = 8,
    parameter int              ADDR_W   = 16,
    parameter int              VEC_W    = 6,
    parameter logic [PC_W-1:0] VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [PC_W-1:0]   word_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic [NIB_W-1:0]  flags_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [SP_W-1:0]   sp_val_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [NIB_W-1:0]  mem_rdata_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [NIB_W-1:0]  mem_wdata_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   pc_o,
    output logic              ie_clr_o,
    output logic              word_vld_o,
    output logic [PC_W-1:0]   word_o,
    output logic              nib_vld_o,
    output logic [NIB_W-1:0]  nib_o,
    output logic              irq_gate_o,
    output logic [SP_W-1:0]   sp1_o,
    output logic [SP_W-1:0]   sp2_o
);

    logic sp1_inc, sp1_dec, sp2_inc, sp2_dec, ld1, ld2;

    dse_ptr #(.W(SP_W)) u_sp1 (
        .clk(clk), .rst_n(rst_n), .inc_i(sp1_inc), .dec_i(sp1_dec),
        .ld_i(ld1), .ld_val_i(sp_val_i), .q_o(sp1_o)
    );

    dse_ptr #(.W(SP_W)) u_sp2 (
        .clk(clk), .rst_n(rst_n), .inc_i(sp2_inc), .dec_i(sp2_dec),
        .ld_i(ld2), .ld_val_i(sp_val_i), .q_o(sp2_o)
    );

    dse_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ld1_i(ld1), .ld2_i(ld2), .open_o(irq_gate_o)
    );

    dse_seq #(
        .PC_W(PC_W), .NIB_W(NIB_W), .SP_W(SP_W), .ADDR_W(ADDR_W),
        .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .word_i(word_i), .nib_i(nib_i),
        .flags_i(flags_i), .pc_i(pc_i), .vec_i(vec_i), .mem_rdata_i(mem_rdata_i),
        .sp1_i(sp1_o), .sp2_i(sp2_o), .gate_i(irq_gate_o),
        .sp1_inc_o(sp1_inc), .sp1_dec_o(sp1_dec), .sp2_inc_o(sp2_inc), .sp2_dec_o(sp2_dec),
        .ld1_o(ld1), .ld2_o(ld2), .busy_o(busy_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .pc_load_o(pc_load_o), .pc_o(pc_o),
        .ie_clr_o(ie_clr_o), .word_vld_o(word_vld_o), .word_o(word_o),
        .nib_vld_o(nib_vld_o), .nib_o(nib_o)
    );

    p_sp2_predec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd_i == C_PUSHN) |=> (sp2_o == $past(sp2_o) - SP_W'(1)));

    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_i == C_LDSP2 && !mem_re_o) |=> (sp2_o == $past(sp2_o)));

    p_hwi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cmd_i == C_HWI && !irq_gate_o) |=> !busy_o);

endmodule

// File: tb/sim_dstack_entry.sv
module sim_dstack_entry;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [15:0] word_i = '0;
    logic [3:0]  nib_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_val_i = '0;
    logic [5:0]  vec_i = '0;
    logic [3:0]  mem_rdata_i;
    logic        busy_o, mem_we_o, mem_re_o, pc_load_o, ie_clr_o;
    logic        word_vld_o, nib_vld_o, irq_gate_o;
    logic [15:0] mem_addr_o, pc_o, word_o;
    logic [3:0]  mem_wdata_o, nib_o;
    logic [7:0]  sp1_o, sp2_o;

    always #10 clk = ~clk;

    dstack_entry u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .word_i(word_i), .nib_i(nib_i),
        .flags_i(flags_i), .pc_i(pc_i), .sp_val_i(sp_val_i), .vec_i(vec_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .pc_load_o(pc_load_o), .pc_o(pc_o), .ie_clr_o(ie_clr_o),
        .word_vld_o(word_vld_o), .word_o(word_o), .nib_vld_o(nib_vld_o),
        .nib_o(nib_o), .irq_gate_o(irq_gate_o), .sp1_o(sp1_o), .sp2_o(sp2_o)
    );

    // Memory seen by the design, and the bench's own expected contents.
    logic [3:0] mem [0:1023];
    logic [3:0] exp_mem [0:1023];
    assign mem_rdata_i = mem[mem_addr_o[9:0]];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;

    // Reference model state.
    int m_sp1 = 0, m_sp2 = 0, m_pend = 0;
    bit m_seen1 = 0, m_seen2 = 0;
    int n_chk = 0, n_fail = 0;

    function automatic logic [31:0] m_gate();
        return 32'((m_seen1 && m_seen2 && m_pend == 0) ? 1 : 0);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One idle-state comparison of pointers, gate and strobes.
    task automatic chk_idle(string req);
        chk(req, 32'(busy_o), 0);
        chk(req, 32'(sp1_o), 32'(m_sp1));
        chk(req, 32'(sp2_o), 32'(m_sp2));
        chk(req, 32'(irq_gate_o), m_gate());
        chk(req, 32'(mem_we_o | mem_re_o), 0);
    endtask

    task automatic t_ld(int which, int val);
        cmd_i = (which == 1) ? 4'd9 : 4'd10;
        sp_val_i = 8'(val);
        @(negedge clk);
        cmd_i = 4'd0;
        if (which == 1) begin
            m_sp1 = val; m_seen1 = 1;
            m_pend = (m_pend == 1) ? 0 : 2;
        end else begin
            m_sp2 = val; m_seen2 = 1;
            m_pend = (m_pend == 2) ? 0 : 1;
        end
        chk_idle("R11 R10 pointer load");
    endtask

    task automatic t_pushn(int n);
        cmd_i = 4'd1; nib_i = 4'(n);
        @(negedge clk);
        cmd_i = 4'd0;
        m_sp2 = (m_sp2 - 1) & 255;
        chk("R3 push write", 32'({busy_o, mem_we_o}), 32'h3);
        chk("R3 push addr", 32'(mem_addr_o), 32'(m_sp2));
        chk("R3 push data", 32'(mem_wdata_o), 32'(n));
        exp_mem[m_sp2] = 4'(n);
        @(negedge clk);
        chk_idle("R3 after push");
    endtask

    task automatic t_popn();
        cmd_i = 4'd2;
        @(negedge clk);
        cmd_i = 4'd0;
        chk("R3 pop read", 32'({busy_o, mem_re_o}), 32'h3);
        chk("R3 pop addr", 32'(mem_addr_o), 32'(m_sp2));
        @(negedge clk);
        chk("R3 pop valid", 32'(nib_vld_o), 1);
        chk("R3 pop data", 32'(nib_o), 32'(exp_mem[m_sp2]));
        m_sp2 = (m_sp2 + 1) & 255;
        chk_idle("R3 R6 after pop");
        @(negedge clk);
        chk("R3 pop pulse", 32'(nib_vld_o), 0);
    endtask

    // kind: 3 word push, 5 call, 7 software irq, 8 hardware irq.
    task automatic t_wpush(int kind, int val, int tgt, int flg, int vec, bit intr);
        int v;
        cmd_i = 4'(kind);
        word_i = 16'((kind == 5) ? tgt : val);
        pc_i = 16'(val);
        flags_i = 4'(flg);
        vec_i = 6'(vec);
        v = (kind == 3) ? val : ((val + 1) & 16'hFFFF);
        @(negedge clk);
        cmd_i = 4'd0;
        if (kind == 7 || kind == 8) begin
            m_sp2 = (m_sp2 - 1) & 255;
            chk("R8 flag write", 32'({busy_o, mem_we_o}), 32'h3);
            chk("R8 flag addr", 32'(mem_addr_o), 32'(m_sp2));
            chk("R8 flag data", 32'(mem_wdata_o), 32'(flg));
            exp_mem[m_sp2] = 4'(flg);
            if (intr) begin
                cmd_i = 4'd10;
                sp_val_i = 8'h77;
            end
            @(negedge clk);
            cmd_i = 4'd0;
        end
        m_sp1 = (m_sp1 - 1) & 255;
        for (int k = 0; k < 4; k++) begin
            chk("R4 word write", 32'({busy_o, mem_we_o}), 32'h3);
            chk("R4 R6 word addr", 32'(mem_addr_o), 32'(m_sp1 * 4 + k));
            chk("R4 word nibble", 32'(mem_wdata_o), 32'((v >> (4 * k)) & 15));
            exp_mem[m_sp1 * 4 + k] = 4'((v >> (4 * k)) & 15);
            @(negedge clk);
        end
        chk_idle(intr ? "R2 ignored while busy" : "R4 after push");
        if (kind == 3) begin
            chk("R4 no pc load", 32'(pc_load_o), 0);
        end else begin
            chk("R7 R8 pc load", 32'(pc_load_o), 1);
            chk("R7 R8 target", 32'(pc_o), 32'((kind == 5) ? tgt : (16'h0100 + vec)));
            chk("R8 R9 ie clear", 32'(ie_clr_o), 32'((kind == 8) ? 1 : 0));
        end
        @(negedge clk);
    endtask

    // kind: 4 word pop, 6 return.
    task automatic t_wpop(int kind);
        int v = 0;
        cmd_i = 4'(kind);
        @(negedge clk);
        cmd_i = 4'd0;
        for (int k = 0; k < 4; k++) begin
            chk("R5 read", 32'({busy_o, mem_re_o}), 32'h3);
            chk("R5 R6 read addr", 32'(mem_addr_o), 32'(m_sp1 * 4 + k));
            v = v | (int'(exp_mem[m_sp1 * 4 + k]) << (4 * k));
            @(negedge clk);
        end
        m_sp1 = (m_sp1 + 1) & 255;
        chk_idle("R5 R6 after pop");
        if (kind == 4) begin
            chk("R5 word valid", 32'({word_vld_o, pc_load_o}), 32'h2);
            chk("R5 word value", 32'(word_o), 32'(v));
        end else begin
            chk("R5 return load", 32'({word_vld_o, pc_load_o}), 32'h1);
            chk("R5 return pc", 32'(pc_o), 32'(v));
        end
        @(negedge clk);
    endtask

    // A command that must leave everything unchanged.
    task automatic t_noeffect(int code, string req);
        cmd_i = 4'(code);
        @(negedge clk);
        cmd_i = 4'd0;
        chk_idle(req);
        @(negedge clk);
        chk(req, 32'(pc_load_o | nib_vld_o | word_vld_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 4'((i * 7) & 15);
            exp_mem[i] = 4'((i * 7) & 15);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_idle("R1 reset state");
        chk("R1 no pc load", 32'(pc_load_o), 0);

        t_noeffect(8, "R9 hw irq masked after reset");
        t_wpush(7, 16'h1234, 0, 4'hA, 6'h3F, 1'b1);
        t_wpop(6);
        t_popn();
        t_ld(1, 8'h40);
        t_noeffect(8, "R9 R10 masked with pair half loaded");
        t_ld(2, 8'h20);
        chk("R10 gate open", 32'(irq_gate_o), 1);
        t_ld(2, 8'h21);
        chk("R10 gate closed by unpaired load", 32'(irq_gate_o), 0);
        t_ld(1, 8'h40);
        chk("R10 gate reopened", 32'(irq_gate_o), 1);
        t_noeffect(15, "R2 undefined code");

        t_pushn(5);
        t_pushn(12);
        t_popn();
        t_popn();
        t_wpush(3, 16'hBEEF, 0, 0, 0, 1'b0);
        t_wpush(3, 16'h1357, 0, 0, 0, 1'b0);
        t_wpop(4);
        t_wpop(4);
        t_wpush(5, 16'h2000, 16'h4321, 0, 0, 1'b0);
        t_wpop(6);
        t_wpush(8, 16'h0FFF, 0, 4'h3, 6'h05, 1'b1);
        t_wpop(6);
        t_popn();
        t_wpush(7, 16'hFFFF, 0, 4'h6, 6'h00, 1'b0);
        t_wpop(6);
        t_popn();
        finish_run();
    end

endmodule